// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block cleans up noisy GPIO inputs before they reach the interrupt detector. Every pin is first brought into the clock domain through a two-flop synchroniser. After that, each pin either passes straight through or goes through a two-sample agreement filter. A per-pin enable bit selects which path the pin takes.

All filtered pins share one sample tick. A single prescaler makes this tick by dividing the peripheral clock by a programmed divisor, so every debounced pin has the same filter period. The divisor is 24 bits wide. When software writes a new divisor, the prescaler count restarts, so the new period takes effect at once. The filtered vector goes only to the interrupt path. Pins whose interrupt is disabled are therefore not affected by the filter in practice.

Software reaches the block through a small register port. The port has a write strobe, a byte offset, write data and combinational read data.

Top module: `gpio_debounce_filter`

## Requirements
- R1: After synchronous reset, the enable vector is 0, the divisor is 0 and every filtered output is 0.
- R2: Offset 0x40 holds the filter-enable vector, with bit i controlling pin i. Offset 0x44 holds the divisor in bits 23:0. Written bits above the stored width are dropped, and reads return the stored value zero-extended to 32 bits. Any other offset reads 0, and a write to it changes nothing.
- R3: A pin whose enable bit is 0 shows its input on its filtered output exactly 3 clock edges after the input changes. This timing does not depend on the tick.
- R4: A pin whose enable bit is 1 changes its filtered output only on a tick, and only when its synchronised input had the same value at that tick and at the previous tick. With a divisor of 0 or 1 a tick occurs on every edge, which gives a latency of exactly 4 edges.
- R5: The tick repeats every D edges for a divisor D of 2 or more. After a divisor write at edge W, ticks fall on edges W+D, W+2D and so on.
- R6: On an enabled pin, an input pulse shorter than D cycles never reaches the filtered output.
- R7: A divisor write restarts the prescaler count, so the new divisor applies from the next edge. The old count has no effect.
- R8: Setting a pin's enable bit does not glitch its filtered output. The filter state is preloaded with the current synchronised input.
- R9: Each pin follows its own enable bit. In the same vector, enabled and disabled pins behave according to R3 and R4 independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| pin_raw | input | NPINS | Asynchronous GPIO inputs |
| pin_clean | output | NPINS | Filtered inputs to the interrupt detector |

## Verification
The bench measures latency on exact edges, not within a window. It expects 3 edges on a bypassed pin, 4 edges with a divisor of 1, and exactly 2D edges after a divisor write on a filtered pin. A prescaler with an off-by-one period, or a filter that needs only one sample, therefore shows up as a change one edge early or late.

A pulse one cycle shorter than the period must be rejected; a filter that accepts a single sample would let it through. A divisor is rewritten while the prescaler is in the middle of a count. A prescaler without a reload would then count to the top of its 24-bit range and the output would stay frozen.

The readback checks look for three faults: bits above bit 23 that are kept, decoding that aliases unknown offsets, and an enable that glitches a pin that is already high.

// File: rtl/gdb_pkg.sv
package gdb_pkg;

    localparam int CFG_AW = 8;
    localparam int CFG_DW = 32;

    // byte offsets seen by software
    localparam logic [CFG_AW-1:0] OFF_ENABLE  = 8'h40;
    localparam logic [CFG_AW-1:0] OFF_DIVISOR = 8'h44;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_DIVISOR
    } cfg_sel_e;

    // per-pin filter state
    typedef struct packed {
        logic meta;   // first synchroniser flop
        logic sync;   // synchronised input
        logic samp;   // value seen at the previous tick
        logic filt;   // filtered output
    } lane_t;

    function automatic cfg_sel_e decode_offset(input logic [CFG_AW-1:0] a);
        if (a == OFF_ENABLE)       return SEL_ENABLE;
        else if (a == OFF_DIVISOR) return SEL_DIVISOR;
        else                       return SEL_NONE;
    endfunction

endpackage

// File: rtl/gdb_regs.sv
module gdb_regs
    import gdb_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DIV_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    output logic [CFG_DW-1:0] rdata,
    output logic [NPINS-1:0]  en_vec,
    output logic [DIV_W-1:0]  div_val,
    output logic              div_wr
);

    cfg_sel_e sel;

    assign sel    = decode_offset(addr);
    assign div_wr = we && (sel == SEL_DIVISOR);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_vec  <= '0;
            div_val <= '0;
        end else if (we) begin
            case (sel)
                SEL_ENABLE:  en_vec  <= wdata[NPINS-1:0];
                SEL_DIVISOR: div_val <= wdata[DIV_W-1:0];
                default:     ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_ENABLE:  rdata[NPINS-1:0] = en_vec;
            SEL_DIVISOR: rdata[DIV_W-1:0] = div_val;
            default:     ;
        endcase
    end

    // R1: reset clears both registers
    a_r1_reset_vals: assert property (@(posedge clk)
        rst |=> (en_vec == '0 && div_val == '0));

    // R2: enable vector only moves on a write to its own offset
    a_r2_en_hold: assert property (@(posedge clk) disable iff (rst)
        !(we && sel == SEL_ENABLE) |=> $stable(en_vec));

endmodule

// File: rtl/gdb_prescaler.sv
module gdb_prescaler #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  logic             reload,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    // divisors 0 and 1 both mean one tick per cycle
    assign last = (div_val <= DIV_W'(1)) ? '0 : div_val - DIV_W'(1);
    assign tick = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (reload) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + DIV_W'(1);
    end

    // R5: count never passes the programmed period
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

    // R7: a divisor write restarts the count
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        reload |=> cnt == '0);

endmodule

// File: rtl/gdb_lane.sv
module gdb_lane
    import gdb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic en,
    input  logic tick,
    output logic filt
);

    lane_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.meta <= raw;
            st.sync <= st.meta;
            if (!en) begin
                // bypass: track input and keep the sample preloaded (R3, R8)
                st.samp <= st.sync;
                st.filt <= st.sync;
            end else if (tick) begin
                st.samp <= st.sync;
                if (st.sync == st.samp) st.filt <= st.sync;
            end
        end
    end

    assign filt = st.filt;

    // R4: an enabled lane never accepts a value that disagrees with the last sample
    a_r4_agree: assert property (@(posedge clk) disable iff (rst)
        (en && tick && st.sync != st.samp) |=> $stable(st.filt));

endmodule

// File: rtl/gpio_debounce_filter.sv
module gpio_debounce_filter
    import gdb_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DIV_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic [NPINS-1:0]  pin_raw,
    output logic [NPINS-1:0]  pin_clean
);

    logic [NPINS-1:0] en_vec;
    logic [DIV_W-1:0] div_val;
    logic             div_wr;
    logic             tick;

    gdb_regs #(.NPINS(NPINS), .DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .en_vec  (en_vec),
        .div_val (div_val),
        .div_wr  (div_wr)
    );

    gdb_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .div_val (div_val),
        .reload  (div_wr),
        .tick    (tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        gdb_lane u_lane (
            .clk  (clk),
            .rst  (rst),
            .raw  (pin_raw[i]),
            .en   (en_vec[i]),
            .tick (tick),
            .filt (pin_clean[i])
        );
    end

    // R4: enabled pins only move on a tick
    a_r4_tick_only: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ((pin_clean ^ $past(pin_clean)) & $past(en_vec)) == '0);

endmodule

// File: tb/sim_gpio_debounce_filter.sv
module sim_gpio_debounce_filter;

    localparam int NP = 16;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NP-1:0] pin_raw = '0;
    logic [NP-1:0] pin_clean;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_debounce_filter #(.NPINS(NP), .DIV_W(24)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pin_raw(pin_raw), .pin_clean(pin_clean)
    );

    // vector table: optional config, pin drive, wait, expected output
    localparam bit          V_CFG  [NV] = '{1, 0, 1, 0, 0, 1, 0, 0};
    localparam logic [15:0] V_EN   [NV] = '{16'h0000, 0, 16'hFFFF, 0, 0, 16'h00FF, 0, 0};
    localparam logic [23:0] V_DIV  [NV] = '{24'd1, 0, 24'd1, 0, 0, 24'd20, 0, 0};
    localparam logic [15:0] V_PIN  [NV] = '{16'hA5A5, 16'h5A5A, 16'hFFFF, 16'hFFFF,
                                            16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF};
    localparam int          V_WAIT [NV] = '{3, 3, 3, 1, 4, 3, 36, 1};
    localparam logic [15:0] V_EXP  [NV] = '{16'hA5A5, 16'h5A5A, 16'h5A5A, 16'hFFFF,
                                            16'h0000, 16'hFF00, 16'hFF00, 16'hFFFF};
    localparam string       V_REQ  [NV] = '{"R3", "R3", "R4", "R4", "R4", "R9", "R5", "R5"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    initial begin
        bit ok;
        cyc(5);
        rst = 1'b0;
        cyc(1);
        // R1: reset state
        check("R1", {16'h0, pin_clean}, 32'h0);
        rd("R1", 8'h40, 32'h0);
        rd("R1", 8'h44, 32'h0);

        // R2: register width, zero extension, unknown offsets
        wr(8'h44, 32'hFF00_0003);
        rd("R2", 8'h44, 32'h0000_0003);
        wr(8'h40, 32'hFFFF_1234);
        rd("R2", 8'h40, 32'h0000_1234);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd("R2", 8'h4C, 32'h0);
        rd("R2", 8'h40, 32'h0000_1234);
        rd("R2", 8'h44, 32'h0000_0003);

        // table walk
        for (int k = 0; k < NV; k++) begin
            if (V_CFG[k]) begin
                wr(8'h40, {16'h0, V_EN[k]});
                wr(8'h44, {8'h0, V_DIV[k]});
            end
            pin_raw = V_PIN[k];
            cyc(V_WAIT[k]);
            check(V_REQ[k], {16'h0, pin_clean}, {16'h0, V_EXP[k]});
        end

        // R6: pulse one cycle shorter than the period is rejected
        wr(8'h40, 32'h0000_FFFF);
        wr(8'h44, 32'd20);
        pin_raw = 16'h0000;
        cyc(19);
        pin_raw = 16'hFFFF;
        cyc(60);
        check("R6", {16'h0, pin_clean}, 32'h0000_FFFF);

        // R7: divisor rewrite mid-count applies at once
        wr(8'h44, 32'd1000);
        pin_raw = 16'h0000;
        cyc(5);
        wr(8'h44, 32'd1);
        cyc(1);
        check("R7", {16'h0, pin_clean}, 32'h0000_FFFF);
        cyc(1);
        check("R7", {16'h0, pin_clean}, 32'h0000_0000);

        // R8: enabling a pin that is already high does not glitch it
        wr(8'h40, 32'h0);
        wr(8'h44, 32'd20);
        pin_raw = 16'hFFFF;
        cyc(3);
        check("R8", {16'h0, pin_clean}, 32'h0000_FFFF);
        wr(8'h40, 32'h0000_FFFF);
        ok = 1'b1;
        for (int k = 0; k < 45; k++) begin
            if (pin_clean !== 16'hFFFF) ok = 1'b0;
            cyc(1);
        end
        check("R8", {31'h0, ok}, 32'h1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule